// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Speculative Store and Undo

This block is a direct-mapped data cache with one data word per line. Its store path does not wait for the tag comparison. In the cycle a store is accepted, the new word goes straight into the indexed data slot. The same array access reads the word it replaces, and that word is saved in a side register. In the following cycle the stored tag and valid bit are compared with the store's address. On a hit the saved word is dropped and the store stands. On a miss the saved word is written back into the slot, which undoes the speculative write. Request acceptance is held off for that one restore cycle.

Loads use the same two-cycle timing. The data word is read and captured in the acceptance cycle, and hit or miss is reported in the next cycle. Every miss, on a load or on a store, raises a one-cycle miss pulse that carries the missing address. An outside controller uses it to allocate the line, which it then installs through the fill port. Fetching from the next level and choosing a victim are left to that controller.

Top module: `spec_wr_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid` and `miss_valid` are 0. The first access to any address misses.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Each accepted request produces exactly one `resp_valid` pulse, in the cycle right after acceptance. No response appears without an accepted request.
- R3: The index is `addr[IDX_W-1:0]` and the tag is `addr[ADDR_W-1:IDX_W]`. `resp_hit` is 1 only when the indexed line is valid and its stored tag equals the request's tag.
- R4: A store writes the data array in the cycle it is accepted. After a store hit, a load accepted in the very next cycle returns the new word.
- R5: On a store miss the original word is put back into the indexed slot. A later load that hits that line returns the original word, never the missed store's data.
- R6: In the response cycle of a store miss, `req_ready` is 0. The restore write happens in that cycle, and `req_ready` returns in the following cycle unless a fill is presented.
- R7: Every miss, on a load or on a store, drives `miss_valid` high for exactly one cycle, in the cycle after the miss response. `miss_addr` holds the full address of the request that missed.
- R8: A load hit returns the stored word on `resp_rdata` in its response cycle.
- R9: When `fill_valid` is 1, the data word, the tag and the valid bit for `fill_addr` are written, and `req_ready` is 0 in that cycle. A fill presented during a restore cycle is ignored.
- R10: Stores that hit are accepted on consecutive cycles with no bubble, and each one lands in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | The request can be accepted this cycle |
| resp_valid | output | 1 | Response for the request accepted in the previous cycle |
| resp_hit | output | 1 | The responding request hit |
| resp_rdata | output | DATA_W | Load data, valid on a load hit |
| miss_valid | output | 1 | One-cycle pulse that asks for allocation |
| miss_addr | output | ADDR_W | Address that missed |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Address of the line to install |
| fill_data | input | DATA_W | Word to install |

## Verification
The bench builds the cache with `ADDR_W=8`, `IDX_W=3` and `DATA_W=32`. With only eight slots and five tag bits, random addresses drawn from three tags land on the same slot often. This brings within easy reach the cases that matter here:
- a store miss that overwrites a slot which holds another tag's live data;
- a load that arrives in the cycle just after a hit store;
- fills that collide with restore cycles.

Directed sequences pin each of these down before the random run.

// File: rtl/spec_wr_cache_pkg.sv
package spec_wr_cache_pkg;

    // Which client owns the single data-array write port in a cycle.
    typedef enum logic [1:0] {
        WP_IDLE    = 2'd0,
        WP_STORE   = 2'd1,
        WP_FILL    = 2'd2,
        WP_RESTORE = 2'd3
    } wport_src_e;

endpackage

// File: rtl/swc_data_array.sv
// One word per slot. Combinational read port, one synchronous write port.
// A read and a write to the same slot in the same cycle return the old word.
module swc_data_array #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/swc_tag_array.sv
// Valid bits and tags, with a combinational lookup port and one write port.
module swc_tag_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [TAG_W-1:0] wtag,
    input  logic [IDX_W-1:0] ridx,
    output logic             rvalid,
    output logic [TAG_W-1:0] rtag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    assign rvalid = valid_q[ridx];
    assign rtag   = tag_q[ridx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else if (we) begin
            valid_q[widx] <= 1'b1;
            tag_q[widx]   <= wtag;
        end
    end
endmodule

// File: rtl/swc_wport_arb.sv
// Picks the owner of the data-array write port.
// Priority: restore, then fill, then speculative store.
module swc_wport_arb
    import spec_wr_cache_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              restore_en,
    input  logic [IDX_W-1:0]  restore_idx,
    input  logic [DATA_W-1:0] restore_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              store_en,
    input  logic [IDX_W-1:0]  store_idx,
    input  logic [DATA_W-1:0] store_data,
    output logic              we,
    output logic [IDX_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata
);
    wport_src_e src;

    always_comb begin
        if (restore_en)    src = WP_RESTORE;
        else if (fill_en)  src = WP_FILL;
        else if (store_en) src = WP_STORE;
        else               src = WP_IDLE;
    end

    always_comb begin
        we    = (src != WP_IDLE);
        waddr = '0;
        wdata = '0;
        unique case (src)
            WP_RESTORE: begin waddr = restore_idx; wdata = restore_data; end
            WP_FILL:    begin waddr = fill_idx;    wdata = fill_data;    end
            WP_STORE:   begin waddr = store_idx;   wdata = store_data;   end
            default:    ;
        endcase
    end
endmodule

// File: rtl/spec_wr_cache.sv
module spec_wr_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    // Check-stage register. The saved word is the undo copy for a store
    // and the load result for a load.
    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] saved;
        logic              miss;
        logic [ADDR_W-1:0] miss_addr;
    } st_t;

    st_t st_d, st_q;

    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] arr_rdata;
    logic              arr_we;
    logic [IDX_W-1:0]  arr_waddr;
    logic [DATA_W-1:0] arr_wdata;
    logic              hit, restore, accept, fill_take, store_take;

    swc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (fill_take),
        .widx   (fill_addr[IDX_W-1:0]),
        .wtag   (fill_addr[ADDR_W-1:IDX_W]),
        .ridx   (st_q.idx),
        .rvalid (lk_valid),
        .rtag   (lk_tag)
    );

    swc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (req_addr[IDX_W-1:0]),
        .rdata (arr_rdata)
    );

    swc_wport_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W)) arb_i (
        .restore_en   (restore),
        .restore_idx  (st_q.idx),
        .restore_data (st_q.saved),
        .fill_en      (fill_take),
        .fill_idx     (fill_addr[IDX_W-1:0]),
        .fill_data    (fill_data),
        .store_en     (store_take),
        .store_idx    (req_addr[IDX_W-1:0]),
        .store_data   (req_wdata),
        .we           (arr_we),
        .waddr        (arr_waddr),
        .wdata        (arr_wdata)
    );

    always_comb begin
        hit        = st_q.busy && lk_valid && (lk_tag == st_q.tag);
        restore    = st_q.busy && st_q.wr && !hit;
        req_ready  = !restore && !fill_valid;
        accept     = req_valid && req_ready;
        fill_take  = fill_valid && !restore;
        store_take = accept && req_write;

        st_d           = st_q;
        st_d.busy      = accept;
        st_d.miss      = st_q.busy && !hit;
        st_d.miss_addr = {st_q.tag, st_q.idx};
        if (accept) begin
            st_d.wr    = req_write;
            st_d.idx   = req_addr[IDX_W-1:0];
            st_d.tag   = req_addr[ADDR_W-1:IDX_W];
            st_d.saved = arr_rdata;   // old word, read before this edge's write
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.busy;
    assign resp_hit   = hit;
    assign resp_rdata = st_q.saved;
    assign miss_valid = st_q.miss;
    assign miss_addr  = st_q.miss_addr;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              fill_valid
);
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else if (req_valid && req_ready) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
        end
    end

    a_r2_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);

    a_r6_stall_on_store_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit && wr_q) |-> !req_ready);

    a_r6_ready_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit && wr_q) |=> (req_ready || fill_valid));

    a_r7_miss_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |=> (miss_valid && miss_addr == $past(addr_q)));

    a_r7_no_spurious_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && !resp_hit) |=> !miss_valid);

    a_r9_fill_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !req_ready);
endmodule

bind spec_wr_cache swc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .fill_valid (fill_valid)
);

// File: tb/spec_wr_cache_tb_top.sv
`timescale 1ns/1ps
module spec_wr_cache_tb_top;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int IW = 3;
    localparam int TW = AW - IW;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_hit, miss_valid;
    logic [DW-1:0] resp_rdata;
    logic [AW-1:0] miss_addr;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;

    always #2.5 clk = ~clk;

    spec_wr_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    int  n_chk = 0, n_bad = 0;
    bit  finished = 1'b0;

    // Reference state
    bit            ref_v [NL];
    logic [TW-1:0] ref_t [NL];
    logic [DW-1:0] ref_d [NL];

    // Pipeline of expectations
    bit            p1_valid = 0, p1_hit = 0, p1_store = 0;
    logic [DW-1:0] p1_rdata = '0;
    logic [AW-1:0] p1_addr = '0;
    string         p1_lbl = "R2";
    bit            p2_miss = 0;
    logic [AW-1:0] p2_addr = '0;

    function automatic bit ref_hit(logic [AW-1:0] a);
        return ref_v[a[IW-1:0]] && (ref_t[a[IW-1:0]] == a[AW-1:IW]);
    endfunction

    task automatic chk(string lbl, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", lbl, what, act, exp, $time);
        end
    endtask

    task automatic step(string lbl, bit v, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                        bit f, logic [AW-1:0] fa, logic [DW-1:0] fd);
        bit restore_now, exp_ready, acc;
        @(negedge clk);
        chk("R2", "resp_valid", 64'(resp_valid), 64'(p1_valid));
        if (p1_valid) begin
            chk(p1_lbl, "resp_hit", 64'(resp_hit), 64'(p1_hit));
            if (!p1_store && p1_hit) chk(p1_lbl, "resp_rdata", 64'(resp_rdata), 64'(p1_rdata));
        end
        chk("R7", "miss_valid", 64'(miss_valid), 64'(p2_miss));
        if (p2_miss) chk("R7", "miss_addr", 64'(miss_addr), 64'(p2_addr));

        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        fill_valid = f; fill_addr = fa; fill_data = fd;
        #1;
        restore_now = p1_valid && p1_store && !p1_hit;
        exp_ready   = !restore_now && !f;
        chk(restore_now ? "R6" : (f ? "R9" : "R2"), "req_ready", 64'(req_ready), 64'(exp_ready));

        p2_miss = p1_valid && !p1_hit;
        p2_addr = p1_addr;
        acc     = v && exp_ready;
        if (f && !restore_now) begin
            ref_v[fa[IW-1:0]] = 1'b1;
            ref_t[fa[IW-1:0]] = fa[AW-1:IW];
            ref_d[fa[IW-1:0]] = fd;
        end
        p1_valid = acc;
        if (acc) begin
            p1_hit   = ref_hit(a);
            p1_store = w;
            p1_rdata = ref_d[a[IW-1:0]];
            p1_addr  = a;
            p1_lbl   = lbl;
            if (w && p1_hit) ref_d[a[IW-1:0]] = d;
        end
    endtask

    task automatic ld(string lbl, logic [AW-1:0] a);
        step(lbl, 1, 0, a, '0, 0, '0, '0);
    endtask
    task automatic st(string lbl, logic [AW-1:0] a, logic [DW-1:0] d);
        step(lbl, 1, 1, a, d, 0, '0, '0);
    endtask
    task automatic fl(string lbl, logic [AW-1:0] a, logic [DW-1:0] d);
        step(lbl, 0, 0, '0, '0, 1, a, d);
    endtask
    task automatic idle();
        step("R2", 0, 0, '0, '0, 0, '0, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) begin ref_v[i] = 0; ref_t[i] = '0; ref_d[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "resp_valid", 64'(resp_valid), 64'd0);
        chk("R1", "miss_valid", 64'(miss_valid), 64'd0);
        ld("R1", 8'h05);                       // cold miss
        idle(); idle();

        // R9, R8: fill then load hit
        fl("R9", 8'h05, 32'hAAAA_0001);
        ld("R8", 8'h05);
        // R4, R10: store hit followed directly by a load of the same line
        st("R4", 8'h05, 32'hBBBB_0002);
        ld("R4", 8'h05);
        idle();

        // R3, R5, R6: store with other tag to slot 5 misses, slot is restored
        st("R3", 8'h25, 32'hCCCC_0003);
        idle();                                 // restore cycle, ready low (R6)
        ld("R5", 8'h05);                        // original word, not CCCC
        ld("R3", 8'h25);                        // still a miss
        idle(); idle();

        // R9: fill during restore is ignored
        st("R6", 8'h45, 32'hDDDD_0004);
        fl("R9", 8'h0A, 32'hEEEE_0005);         // restore cycle: dropped
        ld("R9", 8'h0A);                        // must miss
        ld("R5", 8'h05);
        idle(); idle();

        // R10: back-to-back store hits on different lines
        fl("R9", 8'h01, 32'h1111_0001);
        fl("R9", 8'h02, 32'h2222_0002);
        st("R10", 8'h01, 32'h1111_00A1);
        st("R10", 8'h02, 32'h2222_00A2);
        st("R10", 8'h01, 32'h1111_00B1);
        ld("R10", 8'h01);
        ld("R10", 8'h02);
        idle(); idle();

        // Random mix with frequent slot collisions
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic [AW-1:0] a;
            r = $urandom_range(0, 99);
            a = {5'($urandom_range(0, 2)), 3'($urandom_range(0, NL - 1))};
            if (r < 15)      fl("R9", a, $urandom());
            else if (r < 55) st("R5", a, $urandom());
            else if (r < 92) ld("R8", a);
            else             idle();
        end
        idle(); idle(); idle();
        finish_run();
    end
endmodule